// File: doc/BRIEF.md
# Reset-Configurable FIFO with Selectable Flag Protocol

This block is a single-clock FIFO whose flag protocol is fixed by a mode pin when the block leaves master reset. In standard mode a word is fetched from storage into the output register only when a read is requested. The read-side flag then signals "empty" and the write-side flag signals "full". In first-word-fall-through (FWFT) mode the output register fills itself from storage without any read request. The read-side flag then signals "output ready" and the write-side flag signals "input ready". Both flags are active low in both modes. Two further active-low flags signal almost-empty and almost-full. Each compares the fill level against an offset held in an offset register.

Two asynchronous active-low resets are provided. Master reset clears the pointers, the output register and the offsets. It also arms a one-shot capture of the mode pin, which happens at the first clock edge after the reset is released. Partial reset clears the pointers and the output register only, so the chosen mode and any loaded offsets survive. Offsets are written through a parallel load port, and a load is accepted only while the FIFO is idle.

Top module: `modeflag_fifo`

## Requirements
- R1: While master reset is low, rd_data is all zeroes, pae_n is 0 and paf_n is 1. With mode_sel=0, rd_flag is 0 (empty) and wr_flag is 1 (not full).
- R2: While master reset is low with mode_sel=1, rd_flag is 1 (no output word) and wr_flag is 0 (room for input).
- R3: mode_sel is captured at the first rising clock edge after master reset is released (0 = standard, 1 = FWFT), and later changes to mode_sel have no effect. A write presented at that first edge is ignored.
- R4: In standard mode a read of a non-empty FIFO places the oldest word on rd_data after the edge. rd_flag is 1 while at least one word is stored. A read of an empty FIFO leaves rd_data unchanged.
- R5: In standard mode wr_flag goes to 0 once DEPTH words are stored, and writes while full are discarded.
- R6: In FWFT mode a word written into an empty FIFO appears on rd_data, with rd_flag at 0, one clock after its write edge and without rd_en. rd_en advances to the next word. rd_flag returns to 1 when the last word is read.
- R7: In FWFT mode the capacity is DEPTH+1 words (storage plus the output register). wr_flag goes to 1 when storage holds DEPTH words, and further writes are discarded.
- R8: pae_n is 0 when level <= AE offset. paf_n is 0 when level >= capacity - AF offset. In standard mode level is the stored word count and capacity is DEPTH. In FWFT mode level also counts the output register and capacity is DEPTH+1.
- R9: An offset load (ofs_ld=1) is accepted only when the level is 0 and wr_en is 0. Otherwise the load is ignored.
- R10: Partial reset clears rd_data, the level and the flags as in R1/R2 for the current mode. It keeps the mode and both offsets.
- R11: Master reset restores both offsets to AE_DEF and AF_DEF and re-selects the mode from mode_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst_n | input | 1 | Asynchronous master reset, active low |
| prst_n | input | 1 | Asynchronous partial reset, active low |
| mode_sel | input | 1 | Flag protocol select captured after master reset (1 = FWFT) |
| wr_en | input | 1 | Write enable |
| wr_data | input | WIDTH | Write data |
| rd_en | input | 1 | Read enable |
| rd_data | output | WIDTH | Output register |
| ofs_ld | input | 1 | Offset load strobe |
| ofs_ae | input | AW | Almost-empty offset value |
| ofs_af | input | AW | Almost-full offset value |
| rd_flag | output | 1 | Empty flag (standard) or output-ready flag (FWFT), active low |
| wr_flag | output | 1 | Full flag (standard) or input-ready flag (FWFT), active low |
| pae_n | output | 1 | Almost-empty flag, active low |
| paf_n | output | 1 | Almost-full flag, active low |

## Verification
The bench changes mode_sel after the mode has been captured. A design that re-read the pin would flip the flag meanings in the middle of operation. It fills both modes to capacity and pushes one more word. A FWFT design that ignored the output register's slot would stop at DEPTH words, and one that did not block writes when full would return the extra word during read-back. Partial reset is applied after offsets have been loaded, so a design that reset the offsets or the mode shows a wrong pae_n or wr_flag afterwards. An offset load attempted while the FIFO holds data is also checked: if the design accepted it, pae_n would move.

// File: rtl/cfifo_pkg.sv
package cfifo_pkg;
    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } flag_mode_e;
endpackage

// File: rtl/cfifo_ram.sv
module cfifo_ram #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/cfifo_flags.sv
module cfifo_flags
    import cfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1,
    localparam int LW = AW + 2
) (
    input  flag_mode_e     mode,
    input  logic [CW-1:0]  cnt,
    input  logic           ovalid,
    input  logic [AW-1:0]  ae_ofs,
    input  logic [AW-1:0]  af_ofs,
    output logic [LW-1:0]  level,
    output logic           rd_flag,
    output logic           wr_flag,
    output logic           pae_n,
    output logic           paf_n
);
    logic [LW-1:0] cap;
    logic          ram_full;

    always_comb begin
        ram_full = (cnt == CW'(DEPTH));
        if (mode == MODE_FWFT) begin
            level   = LW'(cnt) + LW'(ovalid);
            cap     = LW'(DEPTH + 1);
            rd_flag = !ovalid;
            wr_flag = ram_full;
        end else begin
            level   = LW'(cnt);
            cap     = LW'(DEPTH);
            rd_flag = (cnt != '0);
            wr_flag = !ram_full;
        end
        pae_n = !(level <= LW'(ae_ofs));
        paf_n = !(level >= (cap - LW'(af_ofs)));
    end
endmodule

// File: rtl/modeflag_fifo.sv
module modeflag_fifo
    import cfifo_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int DEPTH  = 16,
    parameter int AE_DEF = 2,
    parameter int AF_DEF = 2,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1,
    localparam int LW = AW + 2
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic             prst_n,
    input  logic             mode_sel,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    input  logic             ofs_ld,
    input  logic [AW-1:0]    ofs_ae,
    input  logic [AW-1:0]    ofs_af,
    output logic             rd_flag,
    output logic             wr_flag,
    output logic             pae_n,
    output logic             paf_n
);
    typedef struct packed {
        logic [AW-1:0]    wptr;
        logic [AW-1:0]    rptr;
        logic [CW-1:0]    cnt;
        logic             ovalid;
        logic [WIDTH-1:0] dout;
        logic             configured;
        flag_mode_e       mode;
        logic [AW-1:0]    ae;
        logic [AW-1:0]    af;
    } fifo_st_t;

    localparam fifo_st_t MRST_VAL = '{
        wptr: '0, rptr: '0, cnt: '0, ovalid: 1'b0, dout: '0,
        configured: 1'b0, mode: MODE_STD,
        ae: AW'(AE_DEF), af: AW'(AF_DEF)
    };

    fifo_st_t         st_d, st_q;
    flag_mode_e       eff_mode;
    logic [LW-1:0]    level;
    logic [WIDTH-1:0] ram_rdata;
    logic             full_ram, empty_ram, do_wr, do_rd, pop;

    // Before the mode is captured the flags follow the pin, so reset values match R1/R2.
    assign eff_mode = st_q.configured ? st_q.mode : flag_mode_e'(mode_sel);

    always_comb begin
        st_d      = st_q;
        full_ram  = (st_q.cnt == CW'(DEPTH));
        empty_ram = (st_q.cnt == '0);
        do_wr     = wr_en && st_q.configured && !full_ram;
        if (st_q.mode == MODE_FWFT) begin
            pop   = rd_en && st_q.ovalid;
            do_rd = (!st_q.ovalid || pop) && !empty_ram;
        end else begin
            pop   = 1'b0;
            do_rd = rd_en && !empty_ram;
        end

        if (do_wr) st_d.wptr = st_q.wptr + 1'b1;
        if (do_rd) begin
            st_d.rptr = st_q.rptr + 1'b1;
            st_d.dout = ram_rdata;
        end
        if (do_rd && st_q.mode == MODE_FWFT) st_d.ovalid = 1'b1;
        else if (pop)                        st_d.ovalid = 1'b0;

        case ({do_wr, do_rd})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase

        if (!st_q.configured) begin
            st_d.configured = 1'b1;
            st_d.mode       = flag_mode_e'(mode_sel);
        end

        if (ofs_ld && level == '0 && !wr_en) begin
            st_d.ae = ofs_ae;
            st_d.af = ofs_af;
        end
    end

    always_ff @(posedge clk or negedge mrst_n or negedge prst_n) begin
        if (!mrst_n) begin
            st_q <= MRST_VAL;
        end else if (!prst_n) begin
            st_q.wptr   <= '0;
            st_q.rptr   <= '0;
            st_q.cnt    <= '0;
            st_q.ovalid <= 1'b0;
            st_q.dout   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    cfifo_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
        .clk   (clk),
        .we    (do_wr),
        .waddr (st_q.wptr),
        .wdata (wr_data),
        .raddr (st_q.rptr),
        .rdata (ram_rdata)
    );

    cfifo_flags #(.DEPTH(DEPTH)) u_flags (
        .mode    (eff_mode),
        .cnt     (st_q.cnt),
        .ovalid  (st_q.ovalid),
        .ae_ofs  (st_q.ae),
        .af_ofs  (st_q.af),
        .level   (level),
        .rd_flag (rd_flag),
        .wr_flag (wr_flag),
        .pae_n   (pae_n),
        .paf_n   (paf_n)
    );

    assign rd_data = st_q.dout;

    // R5 / R7: stored count never exceeds the storage depth
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        st_q.cnt <= CW'(DEPTH));

    // R5: a write against full storage leaves the write pointer in place
    a_r5_full_blocks_write: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        (wr_en && st_q.cnt == CW'(DEPTH)) |=> $stable(st_q.wptr));

    // R3: nothing enters storage before the mode is captured
    a_r3_unconfigured_no_write: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        !st_q.configured |=> (st_q.cnt == '0));

    // R10: once captured, the mode holds until the next master reset
    a_r10_mode_kept: assert property (@(posedge clk) disable iff (!mrst_n)
        st_q.configured |=> $stable(st_q.mode));

    // R6: in FWFT an empty output register takes a stored word at the next edge
    a_r6_fwft_fall_through: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        (st_q.configured && st_q.mode == MODE_FWFT && !st_q.ovalid && st_q.cnt != '0)
        |=> st_q.ovalid);

    // R9: offsets cannot change while the FIFO holds data
    a_r9_offsets_idle_only: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        (level != '0) |=> ($stable(st_q.ae) && $stable(st_q.af)));
endmodule

// File: tb/tb_modeflag_fifo.sv
module tb_modeflag_fifo;
    localparam int WIDTH = 8;
    localparam int DEPTH = 8;
    localparam int AW    = 3;

    logic             clk = 1'b0;
    logic             mrst_n, prst_n, mode_sel, wr_en, rd_en, ofs_ld;
    logic [WIDTH-1:0] wr_data, rd_data;
    logic [AW-1:0]    ofs_ae, ofs_af;
    logic             rd_flag, wr_flag, pae_n, paf_n;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #5 clk = ~clk;

    modeflag_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AE_DEF(2), .AF_DEF(2)) dut (
        .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .mode_sel(mode_sel),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .ofs_ld(ofs_ld), .ofs_ae(ofs_ae), .ofs_af(ofs_af),
        .rd_flag(rd_flag), .wr_flag(wr_flag), .pae_n(pae_n), .paf_n(paf_n)
    );

    // {wr, rd, din[7:0], rd_flag, wr_flag, pae_n, paf_n, dout[7:0]} for standard mode, offsets 2/2
    localparam logic [21:0] STD_VEC [8] = '{
        {1'b1, 1'b0, 8'h11, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00},
        {1'b1, 1'b0, 8'h22, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00},
        {1'b1, 1'b0, 8'h33, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00},
        {1'b0, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 8'h11},
        {1'b1, 1'b1, 8'h44, 1'b1, 1'b1, 1'b0, 1'b1, 8'h22},
        {1'b0, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 8'h33},
        {1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 8'h44},
        {1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 8'h44}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag, input logic rf, input logic wf,
                           input logic ae, input logic af, input logic [7:0] d);
        chk({tag, " rd_flag"}, 32'(rd_flag), 32'(rf));
        chk({tag, " wr_flag"}, 32'(wr_flag), 32'(wf));
        chk({tag, " pae_n"},   32'(pae_n),   32'(ae));
        chk({tag, " paf_n"},   32'(paf_n),   32'(af));
        chk({tag, " rd_data"}, 32'(rd_data), 32'(d));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        mrst_n = 1'b0; prst_n = 1'b1; mode_sel = 1'b0;
        wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
        ofs_ld = 1'b0; ofs_ae = '0; ofs_af = '0;
        tick(); tick();
        chk_all("R1 std reset", 1'b0, 1'b1, 1'b0, 1'b1, 8'h00);

        // R3: write at the capture edge is dropped
        wr_en = 1'b1; wr_data = 8'h5A; mrst_n = 1'b1;
        tick();
        wr_en = 1'b0;
        chk("R3 write at capture edge ignored", 32'(rd_flag), 32'd0);

        // R4 / R8: vector walk in standard mode
        for (int i = 0; i < 8; i++) begin
            wr_en = STD_VEC[i][21]; rd_en = STD_VEC[i][20]; wr_data = STD_VEC[i][19:12];
            tick();
            chk_all($sformatf("R4/R8 vec%0d", i), STD_VEC[i][11], STD_VEC[i][10],
                    STD_VEC[i][9], STD_VEC[i][8], STD_VEC[i][7:0]);
        end
        wr_en = 1'b0; rd_en = 1'b0;

        // R5: fill to DEPTH, overflow write, read back
        for (int i = 0; i < DEPTH; i++) begin
            wr_en = 1'b1; wr_data = 8'h60 + 8'(i);
            tick();
            if (i == 5) chk("R8 paf_n at level 6", 32'(paf_n), 32'd0);
        end
        chk("R5 wr_flag full", 32'(wr_flag), 32'd0);
        wr_data = 8'hEE;
        tick();
        wr_en = 1'b0;
        chk("R5 still full after extra write", 32'(wr_flag), 32'd0);
        for (int i = 0; i < DEPTH; i++) begin
            rd_en = 1'b1;
            tick();
            chk($sformatf("R5 readback %0d", i), 32'(rd_data), 32'(8'h60 + 8'(i)));
        end
        rd_en = 1'b0;
        tick();
        chk("R4 empty after drain", 32'(rd_flag), 32'd0);

        // R9: load while idle accepted, load while occupied ignored
        ofs_ld = 1'b1; ofs_ae = 3'd0; ofs_af = 3'd0;
        tick();
        ofs_ld = 1'b0;
        wr_en = 1'b1; wr_data = 8'h77;
        tick();
        wr_en = 1'b0;
        chk("R9 idle load takes effect", 32'(pae_n), 32'd1);
        ofs_ld = 1'b1; ofs_ae = 3'd5;
        tick();
        ofs_ld = 1'b0;
        chk("R9 busy load ignored", 32'(pae_n), 32'd1);

        // R10: partial reset keeps mode and offsets
        prst_n = 1'b0;
        #1;
        chk_all("R10 during partial reset", 1'b0, 1'b1, 1'b0, 1'b1, 8'h00);
        tick();
        prst_n = 1'b1;
        wr_en = 1'b1; wr_data = 8'h12;
        tick();
        wr_en = 1'b0;
        chk("R10 std mode kept", 32'(wr_flag), 32'd1);
        chk("R10 ae offset kept", 32'(pae_n), 32'd1);

        // R2 / R11: master reset into FWFT
        mode_sel = 1'b1; mrst_n = 1'b0;
        #1;
        chk_all("R2 fwft reset", 1'b1, 1'b0, 1'b0, 1'b1, 8'h00);
        tick();
        mrst_n = 1'b1;
        tick();
        mode_sel = 1'b0; // R3: later pin changes must not matter

        // R6: fall-through
        wr_en = 1'b1; wr_data = 8'hA1;
        tick();
        wr_en = 1'b0;
        chk("R6 not yet on output", 32'(rd_flag), 32'd1);
        chk("R3 mode held after pin change", 32'(wr_flag), 32'd0);
        tick();
        chk("R6 ready without read", 32'(rd_flag), 32'd0);
        chk("R6 first word shown", 32'(rd_data), 32'hA1);
        chk("R11 default ae restored", 32'(pae_n), 32'd0);
        wr_en = 1'b1; wr_data = 8'hA2; tick();
        wr_data = 8'hA3; tick();
        wr_en = 1'b0;
        rd_en = 1'b1;
        tick(); chk("R6 advance to A2", 32'(rd_data), 32'hA2);
        tick(); chk("R6 advance to A3", 32'(rd_data), 32'hA3);
        tick();
        rd_en = 1'b0;
        chk("R6 drained rd_flag", 32'(rd_flag), 32'd1);
        chk("R6 drained data held", 32'(rd_data), 32'hA3);

        // R7: FWFT capacity DEPTH+1
        for (int i = 0; i <= DEPTH; i++) begin
            wr_en = 1'b1; wr_data = 8'hB0 + 8'(i);
            tick();
        end
        chk("R7 input not ready", 32'(wr_flag), 32'd1);
        chk("R8 fwft paf_n", 32'(paf_n), 32'd0);
        chk("R7 head word", 32'(rd_data), 32'hB0);
        wr_data = 8'hFF;
        tick();
        wr_en = 1'b0;
        for (int i = 1; i <= DEPTH; i++) begin
            rd_en = 1'b1;
            tick();
            chk($sformatf("R7 readback %0d", i), 32'(rd_data), 32'(8'hB0 + 8'(i)));
        end
        tick();
        rd_en = 1'b0;
        chk("R7 empty after DEPTH+1 words", 32'(rd_flag), 32'd1);
        chk("R7 extra word not stored", 32'(rd_data), 32'hB8);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule